// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers the event sources of a bus bridge into one 32-bit status word and turns them into a single level interrupt for the CPU. The sources are the inbound and outbound descriptor engines, an inbound out-of-descriptors condition, a bus abort, and the level of an external device interrupt line. Each source owns a fixed bit position. A bit stays set until software writes a one to it. A mask word selects which status bits may raise the interrupt. A global enable bit gates the output.

Software accesses the block through a single-cycle write port with a two-bit register selector. The status, mask and enable values are brought out as ports. The block also reports the number of the lowest pending, unmasked source. An interrupt handler can use that number to service sources in ascending bit order without scanning the word itself.

Top module: `isr_aggregator`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, the status word, the mask word and the global enable are all zero. In that state `cpu_irq` and `pend_vld` are low.
- R2: A one-cycle pulse on an event input sets its status bit at the next clock edge. The fixed positions are: `in_dsc[3:0]` at bits 3..0, `out_dsc[3:0]` at bits 7..4, `in_starve` at bit 9, `ext_line` at bit 25 and `bus_abort` at bit 26.
- R3: A set status bit holds until a write with `reg_sel`=0 carries a one in that bit position, which clears it. Zero bits in the write data leave their status bits unchanged.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set. A clearing write to other bits in that cycle still takes effect.
- R5: Status bit 25 follows the level of `ext_line`. It is set again on the edge after a clear for as long as the line stays high.
- R6: A write with `reg_sel`=1 loads the mask word, and only the implemented positions (0-7, 9, 25, 26) are kept. Reserved bits of both status and mask always read as zero.
- R7: `cpu_irq` is high exactly when the AND of status and mask is non-zero and the global enable is 1. It is a level and stays high until that condition ends.
- R8: `pend_vld` is high when status AND mask is non-zero. `pend_idx` then gives the lowest set bit position of that AND, and the global enable has no effect on either output.
- R9: A write with `reg_sel`=2 loads the global enable from data bit 0 alone. A write with `reg_sel`=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_dsc | input | 4 | Inbound descriptor event pulses (done, ok, error, end of list) |
| out_dsc | input | 4 | Outbound descriptor event pulses (same order) |
| in_starve | input | 1 | Inbound out-of-descriptors pulse |
| ext_line | input | 1 | External device interrupt level |
| bus_abort | input | 1 | Bus abort pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 status clear, 1 mask, 2 global enable, 3 none |
| reg_wdata | input | 32 | Write data |
| status_q | output | 32 | Status word |
| mask_q | output | 32 | Mask word |
| gen_q | output | 1 | Global enable |
| cpu_irq | output | 1 | Level interrupt to the CPU |
| pend_vld | output | 1 | A pending unmasked source exists |
| pend_idx | output | 5 | Lowest pending unmasked bit position |

## Verification
On every cycle, the assertions check the following: reserved bits stay zero, the interrupt depends on the global enable, the reported index points at a set and unmasked bit, set wins over clear, and the external line re-arms its bit. The clear of an abort bit is also checked each cycle. The bench sweeps every source singly and every pair of sources, with and without masking the lower one. Only these scenarios can show the full bit map, the ordering by priority, and the fact that writes to the unused selector have no effect.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int STAT_W = 32;
  localparam int IDX_W  = $clog2(STAT_W);
  localparam int DSC_N  = 4;
  localparam int POS_IN_DSC  = 0;
  localparam int POS_OUT_DSC = POS_IN_DSC + DSC_N;
  localparam int POS_STARVE  = 9;
  localparam int POS_EXT     = 25;
  localparam int POS_ABORT   = 26;
  localparam logic [STAT_W-1:0] IMPL_MASK =
      (STAT_W'((1 << (2*DSC_N)) - 1)) | (STAT_W'(1) << POS_STARVE) |
      (STAT_W'(1) << POS_EXT) | (STAT_W'(1) << POS_ABORT);

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_GEN    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isr_status_reg.sv
module isr_status_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status_q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (IMPL[g]) begin : g_impl
      logic bit_nxt, bit_q, bit_en;
      always_comb begin
        bit_en  = set_vec[g] | clr_vec[g];
        bit_nxt = set_vec[g] | (bit_q & ~clr_vec[g]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_nxt;
      end
      assign status_q[g] = bit_q;
    end else begin : g_rsvd
      assign status_q[g] = 1'b0;
    end
  end
endmodule

// File: rtl/isr_ctrl_regs.sv
module isr_ctrl_regs #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic         gen_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic         gen_q
);
  logic [W-1:0] mask_nxt;
  logic         gen_nxt;

  always_comb begin
    mask_nxt = wdata & IMPL;
    gen_nxt  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gen_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_nxt;
      if (gen_we)  gen_q  <= gen_nxt;
    end
  end
endmodule

// File: rtl/isr_lowest_find.sv
module isr_lowest_find #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          vld
);
  always_comb begin
    idx = '0;
    vld = |vec;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/isr_aggregator.sv
module isr_aggregator
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DSC_N-1:0]  in_dsc,
  input  logic [DSC_N-1:0]  out_dsc,
  input  logic              in_starve,
  input  logic              ext_line,
  input  logic              bus_abort,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              gen_q,
  output logic              cpu_irq,
  output logic              pend_vld,
  output logic [IDX_W-1:0]  pend_idx
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [STAT_W-1:0] set_vec, clr_vec, pend_vec;
  logic              mask_we, gen_we;
  reg_sel_e          sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    sel     = reg_sel_e'(reg_sel);
    set_vec = '0;
    set_vec[POS_IN_DSC  +: DSC_N] = in_dsc;
    set_vec[POS_OUT_DSC +: DSC_N] = out_dsc;
    set_vec[POS_STARVE] = in_starve;
    set_vec[POS_EXT]    = ext_line;
    set_vec[POS_ABORT]  = bus_abort;
    clr_vec = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;
    mask_we = reg_wr && sel == SEL_MASK;
    gen_we  = reg_wr && sel == SEL_GEN;
  end

  isr_status_reg #(.W(STAT_W), .IMPL(IMPL_MASK)) i_status (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .status_q(status_q));

  isr_ctrl_regs #(.W(STAT_W), .IMPL(IMPL_MASK)) i_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .mask_we(mask_we), .gen_we(gen_we),
    .wdata(reg_wdata), .mask_q(mask_q), .gen_q(gen_q));

  assign pend_vec = status_q & mask_q;

  isr_lowest_find #(.W(STAT_W), .IW(IDX_W)) i_find (
    .vec(pend_vec), .idx(pend_idx), .vld(pend_vld));

  assign cpu_irq = pend_vld & gen_q;
endmodule

// File: rtl/isr_aggregator_chk.sv
module isr_aggregator_chk
  import isr_pkg::*;
(
  input logic              clk,
  input logic              rst_ok,
  input logic [DSC_N-1:0]  in_dsc,
  input logic              ext_line,
  input logic              bus_abort,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [STAT_W-1:0] reg_wdata,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              gen_q,
  input logic              cpu_irq,
  input logic              pend_vld,
  input logic [IDX_W-1:0]  pend_idx
);
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    ((status_q | mask_q) & ~IMPL_MASK) == '0);
  a_r7_irq_needs_gen: assert property (@(posedge clk) disable iff (!rst_ok)
    cpu_irq |-> (gen_q && pend_vld));
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_ok)
    (gen_q && pend_vld) |-> cpu_irq);
  a_r8_idx_points_pending: assert property (@(posedge clk) disable iff (!rst_ok)
    pend_vld |-> (status_q[pend_idx] && mask_q[pend_idx]));
  a_r8_no_lower_pending: assert property (@(posedge clk) disable iff (!rst_ok)
    pend_vld |-> (((status_q & mask_q) & ((STAT_W'(1) << pend_idx) - 1)) == '0));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    in_dsc[0] |=> status_q[0]);
  a_r5_ext_rearms: assert property (@(posedge clk) disable iff (!rst_ok)
    ext_line |=> status_q[POS_EXT]);
  a_r3_abort_clear: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_wr && reg_sel == 2'd0 && reg_wdata[POS_ABORT] && !bus_abort)
      |=> !status_q[POS_ABORT]);
endmodule

bind isr_aggregator isr_aggregator_chk i_chk (
  .clk(clk), .rst_ok(rst_sync_n), .in_dsc(in_dsc), .ext_line(ext_line),
  .bus_abort(bus_abort), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .status_q(status_q), .mask_q(mask_q),
  .gen_q(gen_q), .cpu_irq(cpu_irq), .pend_vld(pend_vld), .pend_idx(pend_idx));

// File: tb/test_isr_aggregator.sv
module test_isr_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_dsc = '0, out_dsc = '0;
  logic        in_starve = 1'b0, ext_line = 1'b0, bus_abort = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status_q, mask_q;
  logic        gen_q, cpu_irq, pend_vld;
  logic [4:0]  pend_idx;

  int checks = 0, errors = 0;
  int pos [11] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 25, 26};
  localparam logic [31:0] IMPL = 32'h0600_02FF;

  always #2.5 clk = ~clk;

  isr_aggregator i_isr_aggregator (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives for one cycle, returns at next negedge.
  task automatic step(logic [31:0] evt, bit wr, logic [1:0] sel, logic [31:0] d);
    in_dsc = evt[3:0]; out_dsc = evt[7:4]; in_starve = evt[9];
    ext_line = evt[25]; bus_abort = evt[26];
    reg_wr = wr; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    in_dsc = '0; out_dsc = '0; in_starve = 1'b0; ext_line = 1'b0;
    bus_abort = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  function automatic int lowest(logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status_q == 0 && mask_q == 0 && !gen_q && !cpu_irq && !pend_vld,
        "R1 in reset", status_q, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(status_q == 0 && mask_q == 0 && !gen_q && !cpu_irq, "R1 after release", status_q, 0);

    // single-source sweep
    for (int k = 0; k < 11; k++) begin
      logic [31:0] b;
      b = 32'h1 << pos[k];
      step(b, 0, 0, 0);
      chk(status_q == b, "R2 bit map", status_q, b);
      chk(!cpu_irq && !pend_vld, "R7 masked no irq", cpu_irq, 0);
      step(0, 1, 0, 0);
      chk(status_q == b, "R3 zero write keeps", status_q, b);
      step(0, 1, 1, 32'hFFFF_FFFF);
      chk(mask_q == IMPL, "R6 mask implemented bits", mask_q, IMPL);
      chk(!cpu_irq && pend_vld && pend_idx == pos[k], "R8 idx without enable",
          pend_idx, pos[k]);
      step(0, 1, 2, 32'h1);
      chk(cpu_irq, "R7 irq with enable", cpu_irq, 1);
      step(0, 1, 0, b);
      chk(status_q == 0 && !cpu_irq && !pend_vld, "R3 w1c clears", status_q, 0);
      step(0, 1, 1, 0);
      step(0, 1, 2, 0);
    end

    // pair sweep for ordering
    step(0, 1, 2, 32'h1);
    for (int i = 0; i < 11; i++) begin
      for (int j = i + 1; j < 11; j++) begin
        logic [31:0] v;
        v = (32'h1 << pos[i]) | (32'h1 << pos[j]);
        step(0, 1, 1, 32'hFFFF_FFFF);
        step(v, 0, 0, 0);
        chk(pend_idx == lowest(v) && cpu_irq, "R8 lowest of pair", pend_idx, lowest(v));
        step(0, 1, 1, ~(32'h1 << pos[i]));
        chk(pend_idx == pos[j] && pend_vld, "R8 lower masked", pend_idx, pos[j]);
        step(0, 1, 0, v);
        chk(status_q == 0, "R3 pair cleared", status_q, 0);
      end
    end

    // set wins over clear
    step(32'h8, 1, 0, 32'h18 | 32'h0);
    chk(status_q[3] == 1'b1, "R4 set beats clear", status_q, 32'h8);
    step(32'h10, 0, 0, 0);
    step(32'h8, 1, 0, 32'h18);
    chk(status_q == 32'h8, "R4 other bit still cleared", status_q, 32'h8);
    step(0, 1, 0, 32'hFFFF_FFFF);

    // external line level
    ext_line = 1'b1;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h1 << 25;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(status_q[25], "R5 re-set while high", status_q, 32'h1 << 25);
    ext_line = 1'b0;
    step(0, 1, 0, 32'h1 << 25);
    chk(status_q == 0, "R5 clears after drop", status_q, 0);

    // selector 3 and enable data bit
    step(0, 1, 2, 0);
    step(0, 1, 1, 0);
    step(0, 1, 3, 32'hFFFF_FFFF);
    chk(!gen_q && mask_q == 0, "R9 sel 3 ignored", mask_q, 0);
    step(0, 1, 2, 32'hFFFF_FFFE);
    chk(!gen_q, "R9 only bit 0 enables", gen_q, 0);
    step(32'hFFFF_FFFF, 0, 0, 0);
    chk(status_q == IMPL, "R6 reserved status zero", status_q, IMPL);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule